// File: doc/BRIEF.md
# Floating Data Bus Value Generator

This block supplies the byte a CPU sees when it reads a port or memory area that nothing drives, on a machine whose display controller is streaming screen bytes from shared memory. It keeps a four-entry history of the bytes the display controller has most recently fetched. The slots hold two pixel/attribute pairs, in the order pixel, attribute, pixel, attribute. From the current beam line and the half-cycle position within the line, it decides whether a fetch window is open. If a window is open, it returns the matching history entry. If not, it returns an idle value.

Two machine variants are selected by `variant_i`. In the early variant (0), fetched bytes pass through unchanged and the idle value is all ones. In the late variant (1), every fetched byte is returned with bit 0 set. The idle value in this variant is the last byte the CPU read from or wrote to contended memory.

The display fetch engine and the CPU bus decode sit outside the block. They present strobes and data to it, and the system read multiplexer takes `float_o` directly.

Top module: `float_bus_gen`

## Requirements
- R1: When `line_i` is 192 or greater, the output is the idle value, whatever the position in the line.
- R2: When `hpos_i` is 256 or greater, the output is the idle value.
- R3: When bit 3 of `hpos_i` is 1, the output is the idle value.
- R4: In all other cases, the output is the history entry whose slot number equals `hpos_i[2:1]`. Slots are numbered 0 to 3 and hold pixel, attribute, pixel, attribute.
- R5: With `variant_i`=1, a history byte is returned with bit 0 forced to 1. With `variant_i`=0, it is returned unchanged.
- R6: With `variant_i`=0, the idle value is 8'hFF.
- R7: With `variant_i`=1, the idle value is the last-contended register. That register loads `cpu_data_i` on a rising clock edge where both `cpu_access_i` and `cpu_contended_i` are 1. An access with `cpu_contended_i`=0 leaves it unchanged.
- R8: On a rising edge with `fetch_we_i`=1, history slot `fetch_slot_i` loads `fetch_data_i`. A read during that same cycle still returns the previous contents. The new byte is visible after the edge.
- R9: Reset sets all four history slots and the last-contended register to 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| variant_i | input | 1 | 0: early variant, 1: late variant |
| line_i | input | 9 | Current beam line |
| hpos_i | input | 9 | Half-cycle position within the line |
| fetch_we_i | input | 1 | Display fetch strobe |
| fetch_slot_i | input | 2 | History slot written by the fetch |
| fetch_data_i | input | 8 | Byte fetched by the display |
| cpu_access_i | input | 1 | CPU memory read or write completes this cycle |
| cpu_contended_i | input | 1 | The CPU access targets a contended bank |
| cpu_data_i | input | 8 | Byte read or written by the CPU |
| float_o | output | 8 | Floating bus value |

## Verification
`float_o` is combinational from the beam inputs, the variant select and the stored state. A change of beam position or variant is therefore due in the same cycle. The bench drives each such change on a falling edge and samples shortly before the next rising edge.

History and last-contended writes take one rising edge. The bench samples once before that edge, where it expects the old value. It samples again at the following falling edge, where it expects the new value.

The beam sweep covers every half-cycle position of a line, on lines inside and outside the display, in both variants. Expected bytes are computed arithmetically from the requirements.

// File: rtl/fb_pkg.sv
package fb_pkg;
  typedef enum logic {
    FB_EARLY = 1'b0,
    FB_LATE  = 1'b1
  } fb_variant_e;

  localparam int unsigned FB_SLOTS = 4;
endpackage

// File: rtl/fb_window.sv
module fb_window #(
  parameter int unsigned LINE_W       = 9,
  parameter int unsigned POS_W        = 9,
  parameter int unsigned ACTIVE_LINES = 192,
  parameter int unsigned ACTIVE_POS   = 256,
  parameter int unsigned GAP_BIT      = 3,
  parameter int unsigned IDX_W        = 2
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic [POS_W-1:0]  hpos_i,
  output logic              active_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic line_ok, pos_ok, in_burst;

  always_comb begin
    line_ok  = line_i < LINE_W'(ACTIVE_LINES);
    pos_ok   = hpos_i < POS_W'(ACTIVE_POS);
    in_burst = ~hpos_i[GAP_BIT];
    active_o = line_ok & pos_ok & in_burst;
    // half-cycle pairs step through the slots
    idx_o    = hpos_i[IDX_W:1];
  end
endmodule

// File: rtl/fb_history.sv
module fb_history #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SLOTS  = 4,
  localparam int unsigned IDX_W = $clog2(SLOTS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [IDX_W-1:0]             slot_i,
  input  logic [DATA_W-1:0]            data_i,
  output logic [SLOTS-1:0][DATA_W-1:0] hist_o
);
  logic [SLOTS-1:0][DATA_W-1:0] hist_q;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_q[g] <= '1;
      else if (we_i && slot_i == IDX_W'(g)) hist_q[g] <= data_i;
    end
  end

  assign hist_o = hist_q;

  p_hist_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(hist_q));
  p_hist_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> hist_q[$past(slot_i)] == $past(data_i));
endmodule

// File: rtl/fb_idle.sv
module fb_idle #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              access_i,
  input  logic              contended_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] last_o
);
  logic [DATA_W-1:0] last_q;
  logic              load;

  assign load = access_i & contended_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   last_q <= '1;
    else if (load) last_q <= data_i;
  end

  assign last_o = last_q;

  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(access_i && contended_i) |=> $stable(last_q));
  p_idle_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access_i && contended_i) |=> last_q == $past(data_i));
endmodule

// File: rtl/float_bus_gen.sv
module float_bus_gen
  import fb_pkg::*;
#(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned LINE_W       = 9,
  parameter int unsigned POS_W        = 9,
  parameter int unsigned ACTIVE_LINES = 192,
  parameter int unsigned ACTIVE_POS   = 256,
  parameter int unsigned GAP_BIT      = 3,
  localparam int unsigned IDX_W       = $clog2(FB_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              variant_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [POS_W-1:0]  hpos_i,
  input  logic              fetch_we_i,
  input  logic [IDX_W-1:0]  fetch_slot_i,
  input  logic [DATA_W-1:0] fetch_data_i,
  input  logic              cpu_access_i,
  input  logic              cpu_contended_i,
  input  logic [DATA_W-1:0] cpu_data_i,
  output logic [DATA_W-1:0] float_o
);
  fb_variant_e                     variant;
  logic                            active;
  logic [IDX_W-1:0]                idx;
  logic [FB_SLOTS-1:0][DATA_W-1:0] hist;
  logic [DATA_W-1:0]               last;
  logic [DATA_W-1:0]               fetch_byte, idle_byte;

  assign variant = fb_variant_e'(variant_i);

  fb_window #(
    .LINE_W(LINE_W), .POS_W(POS_W), .ACTIVE_LINES(ACTIVE_LINES),
    .ACTIVE_POS(ACTIVE_POS), .GAP_BIT(GAP_BIT), .IDX_W(IDX_W)
  ) u_window (
    .line_i(line_i), .hpos_i(hpos_i), .active_o(active), .idx_o(idx)
  );

  fb_history #(.DATA_W(DATA_W), .SLOTS(FB_SLOTS)) u_history (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(fetch_we_i),
    .slot_i(fetch_slot_i), .data_i(fetch_data_i), .hist_o(hist)
  );

  fb_idle #(.DATA_W(DATA_W)) u_idle (
    .clk_i(clk_i), .rst_ni(rst_ni), .access_i(cpu_access_i),
    .contended_i(cpu_contended_i), .data_i(cpu_data_i), .last_o(last)
  );

  always_comb begin
    fetch_byte = hist[idx];
    idle_byte  = '1;
    if (variant == FB_LATE) begin
      fetch_byte[0] = 1'b1;
      idle_byte     = last;
    end
    float_o = active ? fetch_byte : idle_byte;
  end

  p_late_bit0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (variant_i && active) |-> float_o[0]);
  p_early_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!variant_i && !active) |-> float_o == '1);
  p_off_line_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_i >= LINE_W'(ACTIVE_LINES)) |-> !active);
  p_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hpos_i[GAP_BIT] |-> !active);
endmodule

// File: tb/sim_float_bus_gen.sv
module sim_float_bus_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       variant = 1'b0;
  logic [8:0] line = '0;
  logic [8:0] hpos = '0;
  logic       fwe = 1'b0;
  logic [1:0] fslot = '0;
  logic [7:0] fdata = '0;
  logic       cacc = 1'b0;
  logic       ccont = 1'b0;
  logic [7:0] cdata = '0;
  logic [7:0] float_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] hist_m [4];
  logic [7:0] last_m;

  always #10 clk = ~clk;

  float_bus_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .variant_i(variant), .line_i(line),
    .hpos_i(hpos), .fetch_we_i(fwe), .fetch_slot_i(fslot),
    .fetch_data_i(fdata), .cpu_access_i(cacc), .cpu_contended_i(ccont),
    .cpu_data_i(cdata), .float_o(float_o)
  );

  function automatic logic [7:0] model(input logic v, input int ln, input int p);
    logic [7:0] b;
    if (ln >= 192 || p >= 256 || p[3]) return v ? last_m : 8'hFF;
    b = hist_m[p[2:1]];
    return v ? (b | 8'h01) : b;
  endfunction

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (float_o !== exp) begin
      errors++;
      $display("FAIL %s: line=%0d hpos=%0d variant=%0b got %h exp %h",
               req, line, hpos, variant, float_o, exp);
    end
  endtask

  task automatic fetch(input int s, input logic [7:0] d);
    @(negedge clk);
    fwe = 1'b1; fslot = 2'(s); fdata = d;
    @(negedge clk);
    fwe = 1'b0;
    hist_m[s] = d;
  endtask

  function automatic string tag(input int ln, input int p);
    if (ln >= 192) return "R1";
    if (p >= 256) return "R2";
    if (p[3]) return "R3";
    return "R4/R5";
  endfunction

  initial begin
    for (int i = 0; i < 4; i++) hist_m[i] = 8'hFF;
    last_m = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state, both variants
    variant = 1'b0; line = 9'd0; hpos = 9'd2; #5 check("R9", 8'hFF);
    variant = 1'b1; line = 9'd200; #5 check("R9", 8'hFF);

    fetch(0, 8'hA4); fetch(1, 8'h3C); fetch(2, 8'h52); fetch(3, 8'hE0);

    // R8 same-cycle read returns old byte
    @(negedge clk);
    variant = 1'b0; line = 9'd10; hpos = 9'd2;
    fwe = 1'b1; fslot = 2'd1; fdata = 8'h66;
    #5 check("R8", 8'h3C);
    @(negedge clk);
    fwe = 1'b0; hist_m[1] = 8'h66;
    #5 check("R8", 8'h66);

    // R7 non-contended access ignored, contended one loads
    variant = 1'b1; line = 9'd250; hpos = 9'd0;
    @(negedge clk);
    cacc = 1'b1; ccont = 1'b0; cdata = 8'h11;
    @(negedge clk);
    cacc = 1'b0;
    #5 check("R7", 8'hFF);
    @(negedge clk);
    cacc = 1'b1; ccont = 1'b1; cdata = 8'h5A;
    #5 check("R7", 8'hFF);
    @(negedge clk);
    cacc = 1'b0; ccont = 1'b0; last_m = 8'h5A;
    #5 check("R7", 8'h5A);
    // R6 early variant ignores the register
    variant = 1'b0; #2 check("R6", 8'hFF);

    // Sweep: both variants, selected lines, every position
    for (int v = 0; v < 2; v++) begin
      foreach (hist_m[k]) begin end
      for (int li = 0; li < 5; li++) begin
        int ln;
        ln = (li == 0) ? 0 : (li == 1) ? 97 : (li == 2) ? 191 : (li == 3) ? 192 : 310;
        for (int p = 0; p < 456; p++) begin
          @(negedge clk);
          variant = v[0]; line = 9'(ln); hpos = 9'(p);
          #5 check(tag(ln, p), model(v[0], ln, p));
        end
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule